// File: doc/BRIEF.md
# Bit Permute and Transpose Unit

This block rearranges the bits of a 64-bit operand in one of several fixed ways. In gather mode, each of the eight bytes of a second operand names one bit position in the data word. The eight selected bits are packed into a small result. In transpose mode, the data word is treated as an 8x8 bit matrix with one byte per row, and the unit returns the transposed matrix. Three further modes reverse the byte order inside each 16-bit group, inside each 32-bit group, or across the whole 64-bit word.

A request is offered with `in_valid`, an operation code and two operands. The result is registered and appears with `out_valid` exactly one clock later. Requests can be issued back to back, one per cycle. When no request is offered, the output register keeps its last value.

Top module: `bitperm_unit`

## Requirements
- R1: Gather (op code 0): result bit k (k = 0..7) equals bit `data_a[n]`, where n is the low 6 bits of byte k of `data_b` (byte k is `data_b[8k+7:8k]`, bit 0 is the least significant).
- R2: Gather: an index byte whose value is 64 or more gives 0 for its result bit.
- R3: Gather: result bits 63:8 are zero.
- R4: Transpose (op code 1): bit i of output byte j equals bit j of input byte i of `data_a`, for all i, j in 0..7.
- R5: Transposing the result of a transpose returns the original word.
- R6: Op code 2 reverses the two bytes inside each 16-bit group of `data_a`.
- R7: Op code 3 reverses the four bytes inside each 32-bit group of `data_a`.
- R8: Op code 4 reverses all eight bytes of `data_a`.
- R9: Op codes 5, 6 and 7 give a zero result.
- R10: A request with `in_valid` high updates `result` and raises `out_valid` at the next rising edge.
- R11: A cycle without `in_valid` clears `out_valid` at the next edge and leaves `result` unchanged.
- R12: Synchronous active-high reset clears `result` and `out_valid`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Request present this cycle |
| op | input | 3 | Operation code (0 gather, 1 transpose, 2/3/4 byte reversal over 16/32/64 bits) |
| data_a | input | 64 | Data word |
| data_b | input | 64 | Index bytes for gather, ignored otherwise |
| out_valid | output | 1 | Result register holds a new result |
| result | output | 64 | Registered result |

## Verification
Every operation has a latency of exactly one cycle. The bench drives a request just after a falling edge. It samples `result` and `out_valid` at the following falling edge, after the single capturing rising edge. Hold behaviour is checked the same way: an idle cycle with changed operands is followed by one sample, which must show the old result and `out_valid` low. For the double transpose, the first result is fed back as the next request's operand, and the second result is compared with the original word.

// File: rtl/bpu_pkg.sv
package bpu_pkg;

    localparam int WORD_W = 64;
    localparam int LANE_W = 8;
    localparam int LANES  = WORD_W / LANE_W;
    localparam int SEL_W  = $clog2(WORD_W);
    localparam int OP_W   = 3;
    localparam int REV_LEVELS = 3;

    typedef logic [WORD_W-1:0] word_t;

    typedef enum logic [OP_W-1:0] {
        OP_GATHER    = 3'd0,
        OP_TRANSPOSE = 3'd1,
        OP_REV16     = 3'd2,
        OP_REV32     = 3'd3,
        OP_REV64     = 3'd4
    } bpu_op_e;

    typedef struct packed {
        logic  valid;
        word_t data;
    } bpu_out_t;

    function automatic logic op_is_legal(logic [OP_W-1:0] code);
        return code <= OP_REV64;
    endfunction

endpackage

// File: rtl/bpu_gather.sv
module bpu_gather #(
    parameter int WORD_W = 64,
    parameter int LANE_W = 8
) (
    input  logic [WORD_W-1:0] src,
    input  logic [WORD_W-1:0] idx,
    output logic [WORD_W-1:0] res
);
    localparam int LANES = WORD_W / LANE_W;
    localparam int SEL_W = $clog2(WORD_W);

    for (genvar k = 0; k < LANES; k++) begin : g_pick
        logic [LANE_W-1:0] ib;
        assign ib     = idx[k*LANE_W +: LANE_W];
        assign res[k] = (ib[LANE_W-1:SEL_W] == '0) ? src[ib[SEL_W-1:0]] : 1'b0;
    end

    assign res[WORD_W-1:LANES] = '0;
endmodule

// File: rtl/bpu_transpose.sv
module bpu_transpose #(
    parameter int WORD_W = 64,
    parameter int LANE_W = 8
) (
    input  logic [WORD_W-1:0] src,
    output logic [WORD_W-1:0] dst
);
    localparam int ROWS = WORD_W / LANE_W;

    for (genvar r = 0; r < ROWS; r++) begin : g_row
        for (genvar c = 0; c < LANE_W; c++) begin : g_col
            assign dst[c*LANE_W + r] = src[r*LANE_W + c];
        end
    end
endmodule

// File: rtl/bpu_byterev.sv
module bpu_byterev #(
    parameter int WORD_W = 64,
    parameter int LANE_W = 8,
    parameter int GROUP  = 2
) (
    input  logic [WORD_W-1:0] src,
    output logic [WORD_W-1:0] dst
);
    localparam int NGROUPS = WORD_W / (LANE_W * GROUP);

    for (genvar g = 0; g < NGROUPS; g++) begin : g_grp
        for (genvar b = 0; b < GROUP; b++) begin : g_byte
            assign dst[(g*GROUP + b)*LANE_W +: LANE_W] =
                src[(g*GROUP + GROUP - 1 - b)*LANE_W +: LANE_W];
        end
    end
endmodule

// File: rtl/bitperm_unit.sv
module bitperm_unit
    import bpu_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              in_valid,
    input  logic [OP_W-1:0]   op,
    input  logic [WORD_W-1:0] data_a,
    input  logic [WORD_W-1:0] data_b,
    output logic              out_valid,
    output logic [WORD_W-1:0] result
);
    word_t    gat_res;
    word_t    trn_res;
    word_t    rev_res [REV_LEVELS];
    word_t    sel_res;
    bpu_op_e  op_e;
    bpu_out_t out_q;

    assign op_e = bpu_op_e'(op);

    bpu_gather #(.WORD_W(WORD_W), .LANE_W(LANE_W)) u_gather (
        .src(data_a), .idx(data_b), .res(gat_res)
    );

    bpu_transpose #(.WORD_W(WORD_W), .LANE_W(LANE_W)) u_transpose (
        .src(data_a), .dst(trn_res)
    );

    for (genvar lv = 0; lv < REV_LEVELS; lv++) begin : g_rev
        bpu_byterev #(.WORD_W(WORD_W), .LANE_W(LANE_W), .GROUP(2 << lv)) u_rev (
            .src(data_a), .dst(rev_res[lv])
        );
    end

    always_comb begin
        sel_res = '0;
        if (op_is_legal(op)) begin
            case (op_e)
                OP_GATHER:    sel_res = gat_res;
                OP_TRANSPOSE: sel_res = trn_res;
                OP_REV16:     sel_res = rev_res[0];
                OP_REV32:     sel_res = rev_res[1];
                OP_REV64:     sel_res = rev_res[2];
                default:      sel_res = '0;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            out_q <= '0;
        end else begin
            out_q.valid <= in_valid;
            if (in_valid) begin
                out_q.data <= sel_res;
            end
        end
    end

    assign out_valid = out_q.valid;
    assign result    = out_q.data;
endmodule

// File: rtl/bpu_checker.sv
module bpu_checker
    import bpu_pkg::*;
(
    input logic              clk,
    input logic              rst,
    input logic              in_valid,
    input logic [OP_W-1:0]   op,
    input logic [WORD_W-1:0] data_a,
    input logic [WORD_W-1:0] data_b,
    input logic              out_valid,
    input logic [WORD_W-1:0] result
);
    // R12
    reset_clears_chk: assert property (@(posedge clk)
        rst |=> (!out_valid && result == '0));

    // R10
    valid_follows_chk: assert property (@(posedge clk) disable iff (rst)
        in_valid |=> out_valid);

    // R11
    idle_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !in_valid |=> (!out_valid && $stable(result)));

    // R3
    gather_upper_zero_chk: assert property (@(posedge clk) disable iff (rst)
        (in_valid && op == 3'd0) |=> (result[WORD_W-1:LANES] == '0));

    // R1
    gather_bit0_chk: assert property (@(posedge clk) disable iff (rst)
        (in_valid && op == 3'd0 && data_b[7:6] == 2'b00)
        |=> (result[0] == $past(data_a[data_b[5:0]])));

    // R2
    gather_range_chk: assert property (@(posedge clk) disable iff (rst)
        (in_valid && op == 3'd0 && data_b[7:6] != 2'b00) |=> (result[0] == 1'b0));

    // R8
    rev64_chk: assert property (@(posedge clk) disable iff (rst)
        (in_valid && op == 3'd4) |=> (result[7:0] == $past(data_a[63:56])
                                      && result[63:56] == $past(data_a[7:0])));

    // R9
    illegal_op_chk: assert property (@(posedge clk) disable iff (rst)
        (in_valid && op > 3'd4) |=> (result == '0));
endmodule

bind bitperm_unit bpu_checker u_chk (
    .clk(clk), .rst(rst), .in_valid(in_valid), .op(op),
    .data_a(data_a), .data_b(data_b), .out_valid(out_valid), .result(result)
);

// File: tb/sim_bitperm_unit.sv
`timescale 1ns/1ps
module sim_bitperm_unit;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        in_valid = 1'b0;
    logic [2:0]  op = 3'd0;
    logic [63:0] data_a = '0;
    logic [63:0] data_b = '0;
    logic        out_valid;
    logic [63:0] result;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;

    bitperm_unit u0 (
        .clk(clk), .rst(rst), .in_valid(in_valid), .op(op),
        .data_a(data_a), .data_b(data_b), .out_valid(out_valid), .result(result)
    );

    function automatic logic [63:0] exp_of(logic [2:0] o, logic [63:0] a, logic [63:0] b);
        logic [63:0] r = '0;
        case (o)
            3'd0: for (int k = 0; k < 8; k++) begin
                logic [7:0] ix = b[8*k +: 8];
                r[k] = (ix < 8'd64) ? a[ix[5:0]] : 1'b0;
            end
            3'd1: for (int i = 0; i < 8; i++)
                for (int j = 0; j < 8; j++) r[8*j + i] = a[8*i + j];
            3'd2, 3'd3, 3'd4: begin
                int g = (o == 3'd2) ? 2 : (o == 3'd3) ? 4 : 8;
                for (int n = 0; n < 8; n++) begin
                    int base = (n / g) * g;
                    r[8*n +: 8] = a[8*(base + g - 1 - (n - base)) +: 8];
                end
            end
            default: r = '0;
        endcase
        return r;
    endfunction

    task automatic check(string req, logic [63:0] act, logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic issue(logic [2:0] o, logic [63:0] a, logic [63:0] b, string req);
        @(negedge clk);
        in_valid = 1'b1; op = o; data_a = a; data_b = b;
        @(negedge clk);
        check(req, result, exp_of(o, a, b));
        check("R10 out_valid", {63'd0, out_valid}, 64'd1);
        in_valid = 1'b0;
    endtask

    initial begin
        repeat (2000) @(posedge clk);
        if (!done) begin
            errors++; checks++;
            $display("FAIL watchdog: actual hung expected done");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        logic [63:0] x, y, held;
        void'($urandom(32'd1234));
        repeat (3) @(negedge clk);
        check("R12 result after reset", result, 64'd0);
        check("R12 out_valid after reset", {63'd0, out_valid}, 64'd0);
        rst = 1'b0;

        // R1 directed: index bytes 0,63,1,62,7,8,32,31
        issue(3'd0, 64'h8000_0001_0000_0082, 64'h1F20_0807_3E01_3F00, "R1 gather directed");
        // R2: out-of-range indices 64, 255, 128
        issue(3'd0, 64'hFFFF_FFFF_FFFF_FFFF, 64'h0040_FF80_0001_C040, "R2 gather out of range");
        // R3 with all-ones data
        issue(3'd0, 64'hFFFF_FFFF_FFFF_FFFF, 64'h0102_0304_0506_0708, "R3 gather upper zero");
        issue(3'd1, 64'h0102_0408_1020_4080, 64'd0, "R4 transpose anti-diagonal");
        issue(3'd1, 64'h0000_0000_0000_00FF, 64'd0, "R4 transpose row");
        issue(3'd2, 64'h0011_2233_4455_6677, 64'd0, "R6 rev16");
        issue(3'd3, 64'h0011_2233_4455_6677, 64'd0, "R7 rev32");
        issue(3'd4, 64'h0011_2233_4455_6677, 64'd0, "R8 rev64");
        issue(3'd5, 64'hDEAD_BEEF_0123_4567, 64'h0, "R9 op5");
        issue(3'd7, 64'hDEAD_BEEF_0123_4567, 64'h0, "R9 op7");

        // R11: idle cycle with different operands
        held = result;
        @(negedge clk);
        in_valid = 1'b0; op = 3'd4; data_a = 64'h1234_5678_9ABC_DEF0;
        @(negedge clk);
        check("R11 result hold", result, held);
        check("R11 out_valid low", {63'd0, out_valid}, 64'd0);

        // R5: double transpose
        for (int t = 0; t < 20; t++) begin
            x = {$urandom, $urandom};
            issue(3'd1, x, 64'd0, "R4 transpose random");
            y = result;
            issue(3'd1, y, 64'd0, "R4 transpose back");
            check("R5 double transpose", result, x);
        end

        // Random mix, gather indices biased into range
        for (int t = 0; t < 300; t++) begin
            logic [2:0] o = 3'($urandom_range(0, 7));
            logic [63:0] b = {$urandom, $urandom};
            if ($urandom_range(0, 3) != 0) b = b & 64'h3F3F_3F3F_3F3F_3F3F;
            issue(o, {$urandom, $urandom}, b, "R1 R4 R6 R7 R8 R9 random");
        end

        // R12: reset mid-stream
        @(negedge clk);
        in_valid = 1'b1; op = 3'd4; data_a = 64'hFFFF_0000_FFFF_0000; rst = 1'b1;
        @(negedge clk);
        check("R12 reset clears result", result, 64'd0);
        check("R12 reset clears valid", {63'd0, out_valid}, 64'd0);
        rst = 1'b0; in_valid = 1'b0;

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule